// File: doc/BRIEF.md
# Predicated Integer-to-Condition-Field Vector Writer

This block runs a vector operation that turns one bit of an integer source into a row of 4-bit condition fields. The source is either an integer register value or zero, chosen by a register selector. Each element compares the source's least significant bit with a 4-bit mode pattern, lane by lane, under a 4-bit mask. The result goes to the condition field at a base index plus the element number. Each destination predicate bit chooses whether its element gets the compare result, gets forced to zero (when zeroing is on), or is skipped. A row of condition fields can therefore receive a copy of an integer predicate.

A start strobe captures every operand. The block then steps through the elements in order and drives a read port and a write port on an external condition-field file. In merge mode, bits outside the mask must keep their old value, so each element spends one cycle reading its field and one cycle writing it. In overwrite mode no read is needed and each element takes one cycle. A single-cycle done pulse ends every operation.

Top module: `crw_vec_writer`

## Requirements
- R1: Element i (counted from 0) targets field index (base + i) modulo CR_FIELDS, where CR_FIELDS is a power of two. Elements are visited in increasing i.
- R2: If predicate bit i (bit 0 is the least significant) is 1, the element is written. Bit k of the value is mask[k] AND (mode[k] equals s), where s is bit 0 of the source. The source counts as zero when the selector equals 0.
- R3: If predicate bit i is 0 and zeroing is on, the element's field is written with 0000, whatever the source.
- R4: If predicate bit i is 0 and zeroing is off, no write is issued and the field keeps its value.
- R5: With merge on, each element's first cycle raises the read strobe (only when its predicate bit is 1) with the element's index. Read data is expected on crRdData in the next cycle. In that second cycle, written bits outside the mask equal the bits read.
- R6: With merge off, no read is issued. Bits outside the mask are written as 0, and element i is handled in the (i+1)-th cycle after the start edge.
- R7: With merge on, element i occupies cycles 2i+1 and 2i+2 after the start edge. doneOut is high for exactly one cycle, in cycle E*P+1, where E is the element count and P is 1 or 2. With E = 0, done comes in cycle 1 and no port access occurs.
- R8: A start strobe while busy is ignored. Operands are captured only at the accepted start, so changes to the inputs afterwards have no effect.
- R9: A vector length above MAX_VL is treated as MAX_VL.
- R10: After reset, busyOut, doneOut, crRdEn and crWrEn are 0. No read or write strobe is raised while busyOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start strobe, accepted only when idle |
| vlIn | input | $clog2(MAX_VL+1) | Vector length |
| baseIn | input | $clog2(CR_FIELDS) | Field index of element 0 |
| srcSel | input | SEL_W | Source register selector; 0 means the source is zero |
| srcIn | input | XLEN | Integer source value |
| predIn | input | MAX_VL | Destination predicate, bit i for element i |
| zeroIn | input | 1 | Zeroing enable for elements whose predicate bit is 0 |
| maskIn | input | 4 | Lane mask |
| modeIn | input | 4 | Lane compare pattern |
| mergeIn | input | 1 | 1: keep bits outside the mask; 0: clear them |
| crRdData | input | 4 | Field read data, valid the cycle after crRdEn |
| busyOut | output | 1 | Operation in progress, including the done cycle |
| doneOut | output | 1 | One-cycle completion pulse |
| crRdEn | output | 1 | Field read strobe |
| crRdIdx | output | $clog2(CR_FIELDS) | Field read index |
| crWrEn | output | 1 | Field write strobe |
| crWrIdx | output | $clog2(CR_FIELDS) | Field write index |
| crWrData | output | 4 | Field write data |

## Verification
The bench builds the block with MAX_VL = 16 and CR_FIELDS = 16 and keeps the other parameters at their defaults. With these values a vector length of 20 exercises the clamp. A base of 14 wraps the index past the top of the field file. A full-length run covers every predicate bit and every field. A behavioural schedule built for each operation is compared against the port strobes, indices and data on every cycle. A field-file model is then compared in full after each operation.

// File: rtl/crw_pkg.sv
package crw_pkg;

  localparam int FIELD_W = 4;

  typedef logic [FIELD_W-1:0] crField_t;

  typedef struct packed {
    logic load;
    logic rdPhase;
    logic wrPhase;
    logic step;
  } crwStrobe_t;

endpackage

// File: rtl/crw_ctrl.sv
module crw_ctrl
  import crw_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startIn,
  input  logic [VLW-1:0] vlIn,
  input  logic           mergeIn,
  output crwStrobe_t     strobe,
  output logic           busyOut,
  output logic           doneOut
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_FIN} ctrlState_t;

  localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);

  ctrlState_t state;
  logic [VLW-1:0] remCnt;
  logic           mergeFlag;
  logic [VLW-1:0] effVl;

  assign effVl = (vlIn > VL_CAP) ? VL_CAP : vlIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remCnt    <= '0;
      mergeFlag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (startIn) begin
            mergeFlag <= mergeIn;
            remCnt    <= effVl;
            if (effVl == '0) state <= S_FIN;
            else if (mergeIn) state <= S_READ;
            else state <= S_WRITE;
          end
        end
        S_READ:  state <= S_WRITE;
        S_WRITE: begin
          remCnt <= remCnt - VLW'(1);
          if (remCnt == VLW'(1)) state <= S_FIN;
          else if (mergeFlag) state <= S_READ;
          else state <= S_WRITE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load    = (state == S_IDLE) && startIn;
    strobe.rdPhase = (state == S_READ);
    strobe.wrPhase = (state == S_WRITE);
    strobe.step    = (state == S_WRITE);
  end

  assign busyOut = (state != S_IDLE);
  assign doneOut = (state == S_FIN);

  // Busy-cycle counter used only to bound operation length.
  localparam int CW = VLW + 2;
  localparam logic [CW-1:0] CYC_LIMIT = CW'(2 * MAX_VL + 1);
  logic [CW-1:0] cycCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycCnt <= '0;
    else if (!busyOut) cycCnt <= '0;
    else cycCnt <= cycCnt + CW'(1);
  end

  // R7: an operation never exceeds two cycles per element plus done
  a_r7_cycle_budget: assert property (@(posedge clk) disable iff (!rstN)
    busyOut |-> (cycCnt <= CYC_LIMIT));

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

endmodule

// File: rtl/crw_dpath.sv
module crw_dpath
  import crw_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int IDXW   = 6,
  parameter int SEL_W  = 5,
  parameter int XLEN   = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  crwStrobe_t       strobe,
  input  logic [IDXW-1:0]  baseIn,
  input  logic [SEL_W-1:0] srcSel,
  input  logic [XLEN-1:0]  srcIn,
  input  logic [MAX_VL-1:0] predIn,
  input  logic             zeroIn,
  input  crField_t         maskIn,
  input  crField_t         modeIn,
  input  logic             mergeIn,
  input  crField_t         crRdData,
  output logic             crRdEn,
  output logic [IDXW-1:0]  crRdIdx,
  output logic             crWrEn,
  output logic [IDXW-1:0]  crWrIdx,
  output crField_t         crWrData
);

  logic [IDXW-1:0]   elemIdx;
  logic [MAX_VL-1:0] predReg;
  logic              srcBit;
  logic              zeroFlag;
  logic              mergeFlag;
  crField_t          maskReg;
  crField_t          modeReg;

  logic unusedSrcHi;
  assign unusedSrcHi = ^srcIn[XLEN-1:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elemIdx   <= '0;
      predReg   <= '0;
      srcBit    <= 1'b0;
      zeroFlag  <= 1'b0;
      mergeFlag <= 1'b0;
      maskReg   <= '0;
      modeReg   <= '0;
    end else if (strobe.load) begin
      elemIdx   <= baseIn;
      predReg   <= predIn;
      srcBit    <= (srcSel != '0) ? srcIn[0] : 1'b0;
      zeroFlag  <= zeroIn;
      mergeFlag <= mergeIn;
      maskReg   <= maskIn;
      modeReg   <= modeIn;
    end else if (strobe.step) begin
      elemIdx <= elemIdx + IDXW'(1);
      predReg <= predReg >> 1;
    end
  end

  crField_t cmpBits;
  crField_t keepBits;
  logic     activeBit;

  for (genvar g = 0; g < FIELD_W; g++) begin : g_lane
    assign cmpBits[g]  = maskReg[g] & (modeReg[g] == srcBit);
    assign keepBits[g] = mergeFlag & ~maskReg[g] & crRdData[g];
  end

  assign activeBit = predReg[0];
  assign crRdEn    = strobe.rdPhase & activeBit;
  assign crRdIdx   = elemIdx;
  assign crWrEn    = strobe.wrPhase & (activeBit | zeroFlag);
  assign crWrIdx   = elemIdx;
  assign crWrData  = activeBit ? (cmpBits | keepBits) : '0;

  // R5: every read is followed by a write to the same field
  a_r5_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    crRdEn |=> (crWrEn && (crWrIdx == $past(crRdIdx))));

  // R5: bits outside the mask are carried from the read data
  a_r5_keep_outside: assert property (@(posedge clk) disable iff (!rstN)
    (crWrEn && mergeFlag && activeBit) |-> ((crWrData & ~maskReg) == (crRdData & ~maskReg)));

  // R6: overwrite mode never reads
  a_r6_no_read: assert property (@(posedge clk) disable iff (!rstN)
    !mergeFlag |-> !crRdEn);

endmodule

// File: rtl/crw_vec_writer.sv
module crw_vec_writer
  import crw_pkg::*;
#(
  parameter int MAX_VL    = 64,
  parameter int CR_FIELDS = 64,
  parameter int SEL_W     = 5,
  parameter int XLEN      = 64,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int IDXW = $clog2(CR_FIELDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [VLW-1:0]    vlIn,
  input  logic [IDXW-1:0]   baseIn,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic [XLEN-1:0]   srcIn,
  input  logic [MAX_VL-1:0] predIn,
  input  logic              zeroIn,
  input  logic [3:0]        maskIn,
  input  logic [3:0]        modeIn,
  input  logic              mergeIn,
  input  logic [3:0]        crRdData,
  output logic              busyOut,
  output logic              doneOut,
  output logic              crRdEn,
  output logic [IDXW-1:0]   crRdIdx,
  output logic              crWrEn,
  output logic [IDXW-1:0]   crWrIdx,
  output logic [3:0]        crWrData
);

  crwStrobe_t strobe;

  crw_ctrl #(.MAX_VL(MAX_VL)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .vlIn    (vlIn),
    .mergeIn (mergeIn),
    .strobe  (strobe),
    .busyOut (busyOut),
    .doneOut (doneOut)
  );

  crw_dpath #(
    .MAX_VL (MAX_VL),
    .IDXW   (IDXW),
    .SEL_W  (SEL_W),
    .XLEN   (XLEN)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .baseIn   (baseIn),
    .srcSel   (srcSel),
    .srcIn    (srcIn),
    .predIn   (predIn),
    .zeroIn   (zeroIn),
    .maskIn   (maskIn),
    .modeIn   (modeIn),
    .mergeIn  (mergeIn),
    .crRdData (crRdData),
    .crRdEn   (crRdEn),
    .crRdIdx  (crRdIdx),
    .crWrEn   (crWrEn),
    .crWrIdx  (crWrIdx),
    .crWrData (crWrData)
  );

  // R10: the field file is untouched while idle
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |-> (!crRdEn && !crWrEn));

endmodule

// File: tb/crw_vec_writer_tb.sv
module crw_vec_writer_tb_top;

  localparam int MAXV = 16;
  localparam int CRF  = 16;
  localparam int VLW  = $clog2(MAXV + 1);
  localparam int IDXW = $clog2(CRF);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [VLW-1:0] vlIn = '0;
  logic [IDXW-1:0] baseIn = '0;
  logic [4:0] srcSel = '0;
  logic [63:0] srcIn = '0;
  logic [MAXV-1:0] predIn = '0;
  logic zeroIn = 1'b0;
  logic [3:0] maskIn = '0;
  logic [3:0] modeIn = '0;
  logic mergeIn = 1'b0;
  logic [3:0] crRdData;
  logic busyOut, doneOut, crRdEn, crWrEn;
  logic [IDXW-1:0] crRdIdx, crWrIdx;
  logic [3:0] crWrData;

  always #5 clk = ~clk;

  crw_vec_writer #(.MAX_VL(MAXV), .CR_FIELDS(CRF)) dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .vlIn(vlIn), .baseIn(baseIn),
    .srcSel(srcSel), .srcIn(srcIn), .predIn(predIn), .zeroIn(zeroIn),
    .maskIn(maskIn), .modeIn(modeIn), .mergeIn(mergeIn), .crRdData(crRdData),
    .busyOut(busyOut), .doneOut(doneOut), .crRdEn(crRdEn), .crRdIdx(crRdIdx),
    .crWrEn(crWrEn), .crWrIdx(crWrIdx), .crWrData(crWrData)
  );

  // Field file model: registered read, write at the clock edge
  logic [3:0] mem [CRF];
  logic [3:0] rdQ = '0;
  assign crRdData = rdQ;
  always @(posedge clk) begin
    if (crWrEn) mem[crWrIdx] <= crWrData;
    if (crRdEn) rdQ <= mem[crRdIdx];
  end

  int refCr [CRF];
  int checks = 0;
  int fails = 0;

  logic expRdEn [64];
  int   expRdIdx [64];
  logic expWrEn [64];
  int   expWrIdx [64];
  int   expWrData [64];

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    finishRun();
  end

  task automatic checkCycle(string tag, int k, int doneAt);
    logic ok;
    ok = (busyOut == 1'b1) && (doneOut == (k == doneAt)) &&
         (crRdEn == expRdEn[k]) && (crWrEn == expWrEn[k]);
    if (ok && expRdEn[k]) ok = (int'(crRdIdx) == expRdIdx[k]);
    if (ok && expWrEn[k]) ok = (int'(crWrIdx) == expWrIdx[k]) && (int'(crWrData) == expWrData[k]);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual busy=%0b done=%0b rd=%0b/%0d wr=%0b/%0d/%0h expected busy=1 done=%0b rd=%0b/%0d wr=%0b/%0d/%0h",
               tag, k, busyOut, doneOut, crRdEn, crRdIdx, crWrEn, crWrIdx, crWrData,
               k == doneAt, expRdEn[k], expRdIdx[k], expWrEn[k], expWrIdx[k], expWrData[k]);
    end
  endtask

  task automatic runOp(string tag, int vl, int base, int sel, logic [63:0] src,
                       logic [MAXV-1:0] pred, logic zero, logic [3:0] mask,
                       logic [3:0] mode, logic m, logic interfere);
    int ve, per, doneAt;
    for (int k = 0; k < 64; k++) begin
      expRdEn[k] = 1'b0; expWrEn[k] = 1'b0;
      expRdIdx[k] = 0; expWrIdx[k] = 0; expWrData[k] = 0;
    end
    ve = (vl > MAXV) ? MAXV : vl;
    per = m ? 2 : 1;
    doneAt = ve * per + 1;
    for (int e = 0; e < ve; e++) begin
      int idx, cw, lsb, nb;
      idx = (base + e) % CRF;
      cw = m ? 2 * e + 2 : e + 1;
      lsb = (sel != 0) ? int'(src[0]) : 0;
      if (pred[e]) begin
        nb = 0;
        for (int b = 0; b < 4; b++)
          if (mask[b] && (int'(mode[b]) == lsb)) nb += (1 << b);
        if (m) begin
          expRdEn[cw-1] = 1'b1;
          expRdIdx[cw-1] = idx;
          nb |= refCr[idx] & ~int'(mask) & 15;
        end
        expWrEn[cw] = 1'b1; expWrIdx[cw] = idx; expWrData[cw] = nb;
        refCr[idx] = nb;
      end else if (zero) begin
        expWrEn[cw] = 1'b1; expWrIdx[cw] = idx; expWrData[cw] = 0;
        refCr[idx] = 0;
      end
    end
    @(negedge clk);
    startIn = 1'b1; vlIn = VLW'(vl); baseIn = IDXW'(base); srcSel = 5'(sel);
    srcIn = src; predIn = pred; zeroIn = zero; maskIn = mask; modeIn = mode; mergeIn = m;
    @(negedge clk);
    startIn = 1'b0;
    for (int k = 1; k <= doneAt; k++) begin
      if (interfere && k == 2) begin
        startIn = 1'b1; vlIn = VLW'(1); baseIn = ~baseIn; srcIn = ~srcIn;
        predIn = ~predIn; zeroIn = ~zeroIn; maskIn = ~maskIn; modeIn = ~modeIn; mergeIn = ~mergeIn;
      end
      if (interfere && k == 3) startIn = 1'b0;
      checkCycle(tag, k, doneAt);
      @(negedge clk);
    end
    startIn = 1'b0;
    begin
      int bad;
      bad = -1;
      for (int f = 0; f < CRF; f++) if (int'(mem[f]) != refCr[f]) bad = f;
      checks++;
      if (bad >= 0) begin
        fails++;
        $display("FAIL %s field %0d after op: actual=%0h expected=%0h", tag, bad, mem[bad], refCr[bad]);
      end
      checks++;
      if (busyOut !== 1'b0 || doneOut !== 1'b0) begin
        fails++;
        $display("FAIL %s idle after op: actual busy=%0b done=%0b expected 0/0", tag, busyOut, doneOut);
      end
    end
  endtask

  initial begin : main
    for (int f = 0; f < CRF; f++) begin
      mem[f] = 4'((f * 7 + 3) % 16);
      refCr[f] = (f * 7 + 3) % 16;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (busyOut !== 1'b0 || doneOut !== 1'b0 || crRdEn !== 1'b0 || crWrEn !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: actual busy=%0b done=%0b rd=%0b wr=%0b expected 0000",
               busyOut, doneOut, crRdEn, crWrEn);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R2 R6: zero source, overwrite, mask 0011 mode 0000 -> 0011
    runOp("R2", 4, 8, 0, 64'h1, 16'h000F, 1'b0, 4'b0011, 4'b0000, 1'b0, 1'b0);
    // R3: predicate 0b10 with zeroing: field 8 -> 0, field 9 -> 0011
    runOp("R3", 2, 8, 0, 64'h0, 16'h0002, 1'b1, 4'b0011, 4'b0000, 1'b0, 1'b0);
    // R4: skipped elements keep their value; source bit 1 from register 3
    runOp("R4", 4, 0, 3, 64'hF0F1, 16'h0005, 1'b0, 4'b1111, 4'b1010, 1'b0, 1'b0);
    // R5: merge with zeroing, source LSB 0
    runOp("R5", 4, 2, 2, 64'h2, 16'h000B, 1'b1, 4'b0110, 4'b0010, 1'b1, 1'b0);
    // R5: merge without zeroing, source LSB 1
    runOp("R5", 4, 5, 7, 64'h3, 16'h0006, 1'b0, 4'b1001, 4'b1100, 1'b1, 1'b0);
    // R1: index wraps past the top of the field file
    runOp("R1", 5, 14, 1, 64'h1, 16'h001F, 1'b0, 4'b1111, 4'b0101, 1'b0, 1'b0);
    // R7: zero-length operations in both modes
    runOp("R7", 0, 3, 0, 64'h0, 16'hFFFF, 1'b1, 4'b1111, 4'b0000, 1'b0, 1'b0);
    runOp("R7", 0, 3, 0, 64'h0, 16'hFFFF, 1'b1, 4'b1111, 4'b0000, 1'b1, 1'b0);
    // R7: full merge run timing
    runOp("R7", 16, 0, 4, 64'h0, 16'h3C96, 1'b1, 4'b0101, 4'b0001, 1'b1, 1'b0);
    // R9: length above the cap is clamped
    runOp("R9", 20, 6, 0, 64'h0, 16'hA5A5, 1'b1, 4'b1100, 4'b0100, 1'b0, 1'b0);
    // R8: start and operand changes while busy are ignored
    runOp("R8", 4, 10, 5, 64'h1, 16'h0009, 1'b0, 4'b0111, 4'b0010, 1'b1, 1'b1);
    runOp("R6", 3, 12, 9, 64'h0, 16'h0007, 1'b0, 4'b1010, 4'b0000, 1'b0, 1'b1);

    finishRun();
  end

endmodule